// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block sits between a byte-wide host bus and the counting cores of a three-channel interval timer. It has four byte locations. Offsets 0, 1 and 2 are the data ports of channels 0, 1 and 2. Offset 3 takes command words and accepts writes only. A command word picks a channel and then does one of two things: it sets that channel's byte-access scheme and counting mode, or it freezes the channel's current count for a later read.

Data-port writes build a 16-bit reload value. Depending on the access scheme, a value is written as its low byte only, its high byte only, or its low byte followed by its high byte. Once a value is complete, the block sends a one-cycle arm strobe to the channel core. Data-port reads return two bytes, low byte first, then high byte. The bytes come from the frozen count if one is held, otherwise from the live count.

The channel cores report their live count and whether they are running. The block drives each channel's reload value, its mode and its arm strobe.

Top module: `timer_reg_if`

## Requirements
- R1: After reset, every channel has reload value 0 and mode 0, uses the low-then-high write scheme, expects a low byte on both write and read, and holds no frozen count.
- R2: A write to offset 3 is a command. Bits 7:6 select the channel, bits 5:4 the access scheme and bits 3:1 the mode. When the access scheme is nonzero, the command stores the scheme and the mode; mode_o shows the new mode on the cycle after the write. A scheme of 2 makes the next data write a high byte; schemes 1 and 3 make it a low byte.
- R3: A command with access scheme 0 leaves the mode and the access scheme unchanged. It captures count_i only if no frozen count is held; otherwise it is ignored.
- R4: With access scheme 1, each data write replaces bits 7:0 of the reload value and completes the value.
- R5: With access scheme 2, each data write replaces bits 15:8 of the reload value and completes the value.
- R6: With access scheme 3, the first data write replaces bits 7:0 and does not complete the value. The next write replaces bits 15:8, completes the value and returns the channel to expecting a low byte.
- R7: Completing a value pulses arm_o for that channel for one cycle, on the cycle after the write. The exception is a channel whose running_i is high and whose mode is 2; it gets no pulse.
- R8: Reads from a data port alternate between the low byte and the high byte of the live count when no frozen count is held.
- R9: While a frozen count is held, reads return its bytes. Reading its high byte releases it.
- R10: A command with channel field 3 changes no state. A read from offset 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Byte offset: 0..2 data ports, 3 command |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe; advances the byte sequence |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| count_i | input | 48 | Live count of each channel, 16 bits per channel |
| running_i | input | 3 | Channel core is counting |
| reload_o | output | 48 | Reload value of each channel |
| mode_o | output | 9 | Mode of each channel, 3 bits per channel |
| arm_o | output | 3 | One-cycle arm strobe per channel |

## Verification
On every cycle, the assertions check the following:
- An arm pulse only ever follows a write.
- No pulse is given to a running channel in mode 2.
- The mode changes only on a command, and never on a freeze command.
- A held frozen count stays fixed until it is read out.
- Each read flips the byte sequence.

Some behaviour can only be shown by the bench's scenarios:
- The byte values assembled under each access scheme.
- That a second freeze is ignored.
- That reading releases the frozen count and the live count is read again.
- That a channel-3 command leaves all state untouched.

// File: rtl/timer_reg_pkg.sv
package timer_reg_pkg;
  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_LOHI  = 2'd3
  } acc_e;

  localparam logic [2:0] MODE_RATE = 3'd2;

  typedef struct packed {
    logic [1:0] chan;
    acc_e       acc;
    logic [2:0] mode;
  } cmd_t;
endpackage

// File: rtl/timer_cmd_decode.sv
module timer_cmd_decode
  import timer_reg_pkg::*;
#(
  parameter int CH_N = 3
) (
  input  logic            cmd_valid_i,
  input  logic [7:0]      wdata_i,
  output logic [CH_N-1:0] sel_o,
  output acc_e            acc_o,
  output logic [2:0]      mode_o
);
  cmd_t cmd;
  logic unused_bit0;

  assign cmd         = cmd_t'(wdata_i[7:1]);
  assign unused_bit0 = wdata_i[0];
  assign acc_o       = cmd.acc;
  assign mode_o      = cmd.mode;

  // channel field values at or above CH_N select nothing
  for (genvar i = 0; i < CH_N; i++) begin : g_sel
    assign sel_o[i] = cmd_valid_i && (cmd.chan == 2'(i));
  end
endmodule

// File: rtl/timer_chan_regs.sv
module timer_chan_regs
  import timer_reg_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_i,
  input  acc_e              cmd_acc_i,
  input  logic [2:0]        cmd_mode_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              running_i,
  output logic [CNT_W-1:0]  reload_o,
  output logic [2:0]        mode_o,
  output logic              arm_o,
  output logic [BYTE_W-1:0] rdata_o
);
  acc_e              acc_q;
  logic [2:0]        mode_q;
  logic              wr_hi_q, rd_hi_q, latched_q, arm_q;
  logic [CNT_W-1:0]  latch_q, reload_q, rd_src;
  logic              arm_ok;

  assign arm_ok = !(running_i && mode_q == MODE_RATE);
  assign rd_src = latched_q ? latch_q : count_i;
  assign rdata_o = rd_hi_q ? rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= ACC_LOHI;
      mode_q    <= '0;
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      latched_q <= 1'b0;
      latch_q   <= '0;
      reload_q  <= '0;
      arm_q     <= 1'b0;
    end else begin
      arm_q <= 1'b0;
      if (cmd_i) begin
        if (cmd_acc_i != ACC_LATCH) begin
          acc_q   <= cmd_acc_i;
          mode_q  <= cmd_mode_i;
          wr_hi_q <= (cmd_acc_i == ACC_HI);
        end else if (!latched_q) begin
          latched_q <= 1'b1;
          latch_q   <= count_i;
        end
      end else if (wr_i) begin
        if (!wr_hi_q) begin
          reload_q[BYTE_W-1:0] <= wdata_i;
          if (acc_q == ACC_LOHI) wr_hi_q <= 1'b1;
          else                   arm_q   <= arm_ok;
        end else begin
          reload_q[CNT_W-1:BYTE_W] <= wdata_i;
          if (acc_q == ACC_LOHI) wr_hi_q <= 1'b0;
          arm_q <= arm_ok;
        end
      end
      if (rd_i) begin
        rd_hi_q <= ~rd_hi_q;
        if (rd_hi_q && latched_q) latched_q <= 1'b0;
      end
    end
  end

  assign reload_o = reload_q;
  assign mode_o   = mode_q;
  assign arm_o    = arm_q;

  a_r7_arm_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_o |-> $past(wr_i));
  a_r7_no_arm_rate_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i && running_i && mode_q == MODE_RATE) |-> !arm_o);
  a_r2_mode_only_on_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cmd_i) |-> $stable(mode_q));
  a_r3_latch_keeps_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cmd_i && cmd_acc_i == ACC_LATCH) |-> $stable(mode_q) && $stable(acc_q));
  a_r9_latch_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(latched_q) && !$past(rd_i) |-> latched_q && $stable(latch_q));
  a_r8_read_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i) |-> rd_hi_q != $past(rd_hi_q));
endmodule

// File: rtl/timer_reg_if.sv
module timer_reg_if
  import timer_reg_pkg::*;
#(
  parameter int CH_N   = 3,
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            addr_i,
  input  logic [BYTE_W-1:0]     wdata_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  output logic [BYTE_W-1:0]     rdata_o,
  input  logic [CH_N*CNT_W-1:0] count_i,
  input  logic [CH_N-1:0]       running_i,
  output logic [CH_N*CNT_W-1:0] reload_o,
  output logic [CH_N*3-1:0]     mode_o,
  output logic [CH_N-1:0]       arm_o
);
  localparam logic [1:0] CMD_ADDR = 2'd3;

  logic              cmd_valid;
  logic [CH_N-1:0]   cmd_sel;
  acc_e              cmd_acc;
  logic [2:0]        cmd_mode;
  logic [BYTE_W-1:0] ch_rdata [CH_N];

  assign cmd_valid = wr_i && (addr_i == CMD_ADDR);

  timer_cmd_decode #(.CH_N(CH_N)) u_dec (
    .cmd_valid_i (cmd_valid),
    .wdata_i     (wdata_i[7:0]),
    .sel_o       (cmd_sel),
    .acc_o       (cmd_acc),
    .mode_o      (cmd_mode)
  );

  for (genvar i = 0; i < CH_N; i++) begin : g_ch
    logic hit;
    assign hit = (addr_i == 2'(i));
    timer_chan_regs #(.BYTE_W(BYTE_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cmd_i      (cmd_sel[i]),
      .cmd_acc_i  (cmd_acc),
      .cmd_mode_i (cmd_mode),
      .wr_i       (wr_i && hit),
      .rd_i       (rd_i && hit),
      .wdata_i    (wdata_i),
      .count_i    (count_i[i*CNT_W +: CNT_W]),
      .running_i  (running_i[i]),
      .reload_o   (reload_o[i*CNT_W +: CNT_W]),
      .mode_o     (mode_o[i*3 +: 3]),
      .arm_o      (arm_o[i]),
      .rdata_o    (ch_rdata[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < CH_N; i++)
      if (addr_i == 2'(i)) rdata_o = ch_rdata[i];
  end

  a_r10_cmd_one_channel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_sel));
endmodule

// File: tb/timer_reg_if_test.sv
module timer_reg_if_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata;
  logic [47:0] count = '0;
  logic [2:0]  running = '0;
  logic [47:0] reload;
  logic [8:0]  mode;
  logic [2:0]  arm;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { string req; logic [7:0] val; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  timer_reg_if uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .count_i(count),
    .running_i(running), .reload_o(reload), .mode_o(mode), .arm_o(arm)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] a, logic [7:0] e, string req);
    exp_t x;
    x.req = req; x.val = e;
    exp_q.push_back(x);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  // monitor: compares read data against scoreboard
  always begin
    @(negedge clk); #2;
    if (rd) begin
      exp_t x;
      if (exp_q.size() == 0) chk("scoreboard", 32'(rdata), 32'hxx);
      else begin x = exp_q.pop_front(); chk(x.req, 32'(rdata), 32'(x.val)); end
    end
  end

  initial begin
    count[15:0] = 16'hA55A;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reload", 32'(reload), 32'h0);
    chk("R1 mode", 32'(mode), 32'h0);
    chk("R1 arm", 32'(arm), 32'h0);
    bus_rd(2'd0, 8'h5A, "R1/R8 low first");
    bus_rd(2'd0, 8'hA5, "R8 high second");
    bus_rd(2'd0, 8'h5A, "R8 back to low");
    bus_rd(2'd0, 8'hA5, "R8 high again");

    bus_wr(2'd3, 8'h34);               // ch0, lo/hi, mode 2
    chk("R2 mode ch0", 32'(mode[2:0]), 32'd2);
    bus_wr(2'd0, 8'h34);
    chk("R6 no arm after low", 32'(arm), 32'h0);
    bus_wr(2'd0, 8'h12);
    chk("R6/R7 arm ch0", 32'(arm), 32'b001);
    chk("R6 reload ch0", 32'(reload[15:0]), 32'h1234);

    running[0] = 1'b1;
    bus_wr(2'd0, 8'h78);
    bus_wr(2'd0, 8'h56);
    chk("R7 no arm rate running", 32'(arm), 32'h0);
    chk("R7 reload updated", 32'(reload[15:0]), 32'h5678);
    running[0] = 1'b0;

    bus_wr(2'd3, 8'h50);               // ch1, low only, mode 0
    bus_wr(2'd1, 8'hAB);
    chk("R4 arm ch1", 32'(arm), 32'b010);
    chk("R4 reload ch1", 32'(reload[31:16]), 32'h00AB);
    bus_wr(2'd3, 8'h66);               // ch1, high only, mode 3
    chk("R2 mode ch1", 32'(mode[5:3]), 32'd3);
    bus_wr(2'd1, 8'hCD);
    chk("R5 arm ch1", 32'(arm), 32'b010);
    chk("R5 reload ch1", 32'(reload[31:16]), 32'hCDAB);
    bus_wr(2'd1, 8'hEF);
    chk("R5 repeat high", 32'(reload[31:16]), 32'hEFAB);

    count[47:32] = 16'h1357;
    bus_wr(2'd3, 8'h8A);               // ch2 latch, mode bits 5
    chk("R3 mode unchanged", 32'(mode[8:6]), 32'd0);
    count[47:32] = 16'h2468;
    bus_wr(2'd3, 8'h80);               // second latch ignored
    bus_rd(2'd2, 8'h57, "R9 latched low");
    bus_rd(2'd2, 8'h13, "R3/R9 latched high");
    bus_rd(2'd2, 8'h68, "R9 released live low");
    bus_rd(2'd2, 8'h24, "R9 released live high");

    bus_wr(2'd3, 8'hDE);               // channel 3 command
    chk("R10 modes untouched", 32'(mode), 32'({3'd0, 3'd3, 3'd2}));
    chk("R10 no arm", 32'(arm), 32'h0);
    bus_rd(2'd3, 8'h00, "R10 offset 3 reads 0");
    bus_wr(2'd0, 8'h11);
    chk("R10 ch0 still lo/hi", 32'(arm), 32'h0);
    bus_wr(2'd0, 8'h22);
    chk("R10 ch0 completes", 32'(reload[15:0]), 32'h2211);
    chk("R10 ch0 arm", 32'(arm), 32'b001);

    repeat (3) @(negedge clk);
    chk("scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule